// File: doc/BRIEF.md
# Power-Gating Event Spacing Guard

This block decides, cycle by cycle, whether a power-gating transition of a processing unit may begin now. Each power-up or power-down of a unit disturbs the supply of its neighbours. Those neighbours are protected by stopping their clocks for a window that covers the transition. Two transitions must not have protection windows that overlap. The block records the time of the most recent power-up start and the most recent power-down end. For each new request, it checks the time elapsed since each record against a minimum gap. That gap depends on which kind of event came first and which kind is requested.

The minimum gaps are built from four timing parameters: the clock-stop time, the clock-restart time, the power-up settle time and the power-down settle time. A requester raises `req_valid` with the event kind. It keeps the request raised until `grant` is high. In that same cycle it raises the commit strobe for that kind, which records the event time. `grant` is a combinational function of the request and the stored history, so it adds no cycle of latency. The block does not choose a unit or a task.

Top module: `gating_spacing_checker`

## Requirements
- R1: After reset, before any commit, a request of either kind is granted in the cycle it is raised.
- R2: A power-down request k cycles after a power-up commit is granted only when k >= ON_SETTLE_CYC + OFF_SETTLE_CYC + CLK_OFF_CYC + CLK_ON_CYC.
- R3: A power-down request k cycles after a power-down commit is granted only when k >= CLK_OFF_CYC + OFF_SETTLE_CYC + CLK_ON_CYC.
- R4: A power-up request k cycles after a power-up commit is granted only when k >= CLK_OFF_CYC + ON_SETTLE_CYC + CLK_ON_CYC.
- R5: A power-up request k cycles after a power-down commit is granted only when k >= CLK_OFF_CYC + CLK_ON_CYC.
- R6: When both kinds of event are on record, a request is granted only when the gaps from both records are met, so the stricter of the two decides.
- R7: A request that is too early is not lost. While `req_valid` stays high, `grant` rises in exactly the first cycle in which the gaps are met.
- R8: A commit strobe, raised in a cycle where a request of the same kind is granted, stores that cycle as the event time. The next cycle counts as one cycle of separation.
- R9: `grant` is low in every cycle where `req_valid` is low.
- R10: A record is dropped once the longest gap has elapsed. After an arbitrarily long idle time, requests of both kinds are granted at once, even though the internal time counter has wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the history |
| req_valid | input | 1 | A transition is requested this cycle |
| req_is_on | input | 1 | Kind of the requested transition: 1 = power-up, 0 = power-down |
| commit_on | input | 1 | Records a power-up start at this cycle |
| commit_off | input | 1 | Records a power-down end at this cycle |
| grant | output | 1 | The requested transition may begin this cycle |

## Verification
The assertions assume that a commit strobe is raised only together with a granted request of the same kind, and never two strobes in one cycle. Without this, a record could hold a time the block never allowed, and the spacing properties would flag correct logic. The bench drives every commit through one task. That task raises the strobe with the request, at a cycle whose elapsed gaps the bench has already shown to be sufficient. Probes leave both strobes low, so they test the grant decision without changing the history.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

    typedef enum logic {
        KIND_OFF = 1'b0,
        KIND_ON  = 1'b1
    } gate_kind_e;

    // Minimum separation between a recorded event of kind prev and a new event of kind next.
    function automatic int unsigned gap_cycles(
        input gate_kind_e  prev,
        input gate_kind_e  next,
        input int unsigned clk_off,
        input int unsigned clk_on,
        input int unsigned on_settle,
        input int unsigned off_settle
    );
        int unsigned g;
        if (prev == KIND_ON && next == KIND_OFF)      g = clk_on + clk_off + off_settle + on_settle;
        else if (prev == KIND_OFF && next == KIND_OFF) g = off_settle + clk_on + clk_off;
        else if (prev == KIND_ON && next == KIND_ON)   g = on_settle + clk_off + clk_on;
        else                                           g = clk_on + clk_off;
        return g;
    endfunction

endpackage

// File: rtl/gsc_timebase.sv
module gsc_timebase #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] now
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign now = cnt_q;

endmodule

// File: rtl/gsc_window.sv
module gsc_window #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned MAX_SEP = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] now,
    input  logic             commit,
    output logic             seen,
    output logic [CNT_W-1:0] elapsed
);

    localparam logic [CNT_W-1:0] MAX_L = CNT_W'(MAX_SEP);

    typedef struct packed {
        logic             seen;
        logic [CNT_W-1:0] stamp;
    } win_t;

    win_t win_d, win_q;

    assign elapsed = now - win_q.stamp;
    assign seen    = win_q.seen;

    always_comb begin
        win_d = win_q;
        if (commit) begin
            win_d.seen  = 1'b1;
            win_d.stamp = now;
        end else if (win_q.seen && (elapsed >= MAX_L)) begin
            // The longest gap has passed, so this record can no longer block anything.
            win_d.seen = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    generate
        if (MAX_SEP > 1) begin : g_fresh
            assert_stamp_fresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
                commit |=> (seen && elapsed == CNT_W'(1)));
        end
    endgenerate

    assert_age_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !commit && elapsed >= MAX_L) |=> !seen);

endmodule

// File: rtl/gsc_rule.sv
module gsc_rule #(
    parameter int unsigned CNT_W         = 8,
    parameter int unsigned GAP_AFTER_ON  = 4,
    parameter int unsigned GAP_AFTER_OFF = 4
) (
    input  logic             seen_on,
    input  logic [CNT_W-1:0] el_on,
    input  logic             seen_off,
    input  logic [CNT_W-1:0] el_off,
    output logic             ok
);

    localparam logic [CNT_W-1:0] GAP_ON_L  = CNT_W'(GAP_AFTER_ON);
    localparam logic [CNT_W-1:0] GAP_OFF_L = CNT_W'(GAP_AFTER_OFF);

    logic ok_on, ok_off;

    always_comb begin
        ok_on  = !seen_on  || (el_on  >= GAP_ON_L);
        ok_off = !seen_off || (el_off >= GAP_OFF_L);
        ok     = ok_on && ok_off;
    end

endmodule

// File: rtl/gating_spacing_checker.sv
module gating_spacing_checker #(
    parameter int unsigned CLK_OFF_CYC    = 100,
    parameter int unsigned CLK_ON_CYC     = 100,
    parameter int unsigned ON_SETTLE_CYC  = 200,
    parameter int unsigned OFF_SETTLE_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_is_on,
    input  logic commit_on,
    input  logic commit_off,
    output logic grant
);

    import gsc_pkg::*;

    localparam int unsigned GAP_ON_OFF  = gap_cycles(KIND_ON,  KIND_OFF, CLK_OFF_CYC, CLK_ON_CYC, ON_SETTLE_CYC, OFF_SETTLE_CYC);
    localparam int unsigned GAP_OFF_OFF = gap_cycles(KIND_OFF, KIND_OFF, CLK_OFF_CYC, CLK_ON_CYC, ON_SETTLE_CYC, OFF_SETTLE_CYC);
    localparam int unsigned GAP_ON_ON   = gap_cycles(KIND_ON,  KIND_ON,  CLK_OFF_CYC, CLK_ON_CYC, ON_SETTLE_CYC, OFF_SETTLE_CYC);
    localparam int unsigned GAP_OFF_ON  = gap_cycles(KIND_OFF, KIND_ON,  CLK_OFF_CYC, CLK_ON_CYC, ON_SETTLE_CYC, OFF_SETTLE_CYC);
    localparam int unsigned MAX_SEP     = GAP_ON_OFF;
    localparam int unsigned CNT_W       = $clog2(MAX_SEP + 1) + 1;

    logic [CNT_W-1:0] now;
    logic [1:0]       commit_vec;
    logic [1:0]       seen_vec;
    logic [CNT_W-1:0] el_vec [2];
    logic [1:0]       ok_vec;

    // Index 0 = power-down record, index 1 = power-up record.
    assign commit_vec = {commit_on, commit_off};

    gsc_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (now)
    );

    generate
        for (genvar k = 0; k < 2; k++) begin : g_win
            gsc_window #(.CNT_W(CNT_W), .MAX_SEP(MAX_SEP)) u_win (
                .clk     (clk),
                .rst_n   (rst_n),
                .now     (now),
                .commit  (commit_vec[k]),
                .seen    (seen_vec[k]),
                .elapsed (el_vec[k])
            );
        end

        for (genvar j = 0; j < 2; j++) begin : g_rule
            localparam gate_kind_e NEXT = (j == 1) ? KIND_ON : KIND_OFF;
            gsc_rule #(
                .CNT_W         (CNT_W),
                .GAP_AFTER_ON  (gap_cycles(KIND_ON,  NEXT, CLK_OFF_CYC, CLK_ON_CYC, ON_SETTLE_CYC, OFF_SETTLE_CYC)),
                .GAP_AFTER_OFF (gap_cycles(KIND_OFF, NEXT, CLK_OFF_CYC, CLK_ON_CYC, ON_SETTLE_CYC, OFF_SETTLE_CYC))
            ) u_rule (
                .seen_on  (seen_vec[1]),
                .el_on    (el_vec[1]),
                .seen_off (seen_vec[0]),
                .el_off   (el_vec[0]),
                .ok       (ok_vec[j])
            );
        end
    endgenerate

    assign grant = req_valid && ok_vec[req_is_on];

    // The history is empty: nothing may block.
    assert_empty_history_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seen_vec == 2'b00) |-> grant);

    // Input contract: a commit strobe comes only with a granted request of its own kind.
    assert_commit_on_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_on |-> (req_valid && req_is_on && grant && !commit_off));
    assert_commit_off_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_off |-> (req_valid && !req_is_on && grant && !commit_on));

    generate
        if (GAP_ON_OFF > 1) begin : g_a2
            assert_on_then_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
                commit_on |=> !(req_valid && !req_is_on && grant));
        end
        if (GAP_OFF_OFF > 1) begin : g_a3
            assert_off_then_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
                commit_off |=> !(req_valid && !req_is_on && grant));
        end
        if (GAP_ON_ON > 1) begin : g_a4
            assert_on_then_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
                commit_on |=> !(req_valid && req_is_on && grant));
        end
        if (GAP_OFF_ON > 1) begin : g_a5
            assert_off_then_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
                commit_off |=> !(req_valid && req_is_on && grant));
        end
    endgenerate

endmodule

// File: tb/tb_gating_spacing_checker.sv
`timescale 1ns/1ps
module tb_gating_spacing_checker;

    localparam int unsigned C_OFF = 3;
    localparam int unsigned C_ON  = 2;
    localparam int unsigned S_ON  = 5;
    localparam int unsigned S_OFF = 7;
    localparam int unsigned G_ON_OFF  = S_ON + S_OFF + C_OFF + C_ON;   // 17
    localparam int unsigned G_OFF_OFF = C_OFF + S_OFF + C_ON;          // 12
    localparam int unsigned G_ON_ON   = C_OFF + S_ON + C_ON;           // 10
    localparam int unsigned G_OFF_ON  = C_OFF + C_ON;                  // 5

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_is_on = 1'b0;
    logic commit_on = 1'b0;
    logic commit_off = 1'b0;
    logic grant;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gating_spacing_checker #(
        .CLK_OFF_CYC    (C_OFF),
        .CLK_ON_CYC     (C_ON),
        .ON_SETTLE_CYC  (S_ON),
        .OFF_SETTLE_CYC (S_OFF)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_is_on  (req_is_on),
        .commit_on  (commit_on),
        .commit_off (commit_off),
        .grant      (grant)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: grant actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic on, input logic c_on, input logic c_off);
        @(negedge clk);
        req_valid  = v;
        req_is_on  = on;
        commit_on  = c_on;
        commit_off = c_off;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic commit_ev(input logic is_on, input string tag);
        drive(1'b1, is_on, is_on, !is_on);
        chk(grant, 1'b1, tag);
    endtask

    task automatic probe(input logic is_on, input logic exp, input string tag);
        drive(1'b1, is_on, 1'b0, 1'b0);
        chk(grant, exp, tag);
    endtask

    // Let every record age out so each scenario starts from an empty history.
    task automatic settle();
        idle(G_ON_OFF + 3);
    endtask

    task automatic t_reset();
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        chk(grant, 1'b0, "R9 reset idle");
        probe(1'b1, 1'b1, "R1 first power-up");
        probe(1'b0, 1'b1, "R1 first power-down");
    endtask

    task automatic t_scan(input logic prev_on, input logic next_on, input int unsigned gap, input string tag);
        settle();
        commit_ev(prev_on, "R8 commit");
        for (int k = 1; k <= int'(gap); k++) probe(next_on, (k >= int'(gap)), tag);
    endtask

    task automatic t_defer();
        settle();
        commit_ev(1'b1, "R8 commit");
        for (int k = 1; k < int'(G_ON_OFF); k++) probe(1'b0, 1'b0, "R7 held early");
        commit_ev(1'b0, "R7 held granted on time");
        for (int k = 1; k <= int'(G_OFF_ON); k++) probe(1'b1, (k >= int'(G_OFF_ON)), "R8 new stamp");
    endtask

    task automatic t_both();
        settle();
        commit_ev(1'b0, "R8 commit");
        for (int k = 1; k < int'(G_OFF_ON); k++) probe(1'b1, 1'b0, "R5 early");
        commit_ev(1'b1, "R6 up after down");
        for (int k = 1; k <= int'(G_ON_OFF); k++) probe(1'b0, (k >= int'(G_ON_OFF)), "R6 stricter");
    endtask

    task automatic t_idle_req();
        settle();
        commit_ev(1'b1, "R8 commit");
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        chk(grant, 1'b0, "R9 no request");
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        chk(grant, 1'b0, "R9 no request kind up");
    endtask

    task automatic t_wrap();
        settle();
        commit_ev(1'b0, "R8 commit");
        idle(66);
        probe(1'b1, 1'b1, "R10 up after wrap");
        probe(1'b0, 1'b1, "R10 down after wrap");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_scan(1'b1, 1'b0, G_ON_OFF,  "R2 up then down");
        t_scan(1'b0, 1'b0, G_OFF_OFF, "R3 down then down");
        t_scan(1'b1, 1'b1, G_ON_ON,   "R4 up then up");
        t_scan(1'b0, 1'b1, G_OFF_ON,  "R5 down then up");
        t_defer();
        t_both();
        t_idle_req();
        t_wrap();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule